// File: doc/BRIEF.md
# Transmit Frame Descriptor Walker

This block takes in one 128-byte transmit frame descriptor as a stream of 32-bit words. It decodes the packed list of scatter buffers in that descriptor. For each buffer that carries data, it issues one read request with a 36-bit address and a 12-bit length. It does not perform the memory reads or move any payload. A downstream fetch engine consumes the requests and later supplies the next descriptor.

After the whole descriptor is captured, the walker reads the buffer count from the header byte. It builds a set of live entries, then issues requests in ascending entry order, one request per accepted handshake. It keeps a running frame length. A single-cycle done pulse closes each descriptor, and an error flag may accompany it. The error is raised when the count is too large, when one buffer exceeds its size limit, or when the frame exceeds its total limit.

A side output computes where a descriptor sits in host memory. It takes a 256-byte-aligned ring base and a slot index, and returns the ring base plus 128 bytes per slot.

Top module: `tfd_walker`

## Requirements
- R1: `desc_addr` equals `ring_base` shifted left by 8, plus `ring_idx` times 128, as a 36-bit value.
- R2: While it accepts input, `wd_ready` is high. Exactly 32 words make up one descriptor. Word w carries descriptor bytes 4w to 4w+3, with the lowest byte in bits 7:0.
- R3: The buffer count is bits 4:0 of byte 3 (word 0 bits 28:24). Bits 7:5 of that byte have no effect on requests, error or length.
- R4: Entry i occupies bytes 4+6i to 9+6i. Its first four bytes are address bits 31:0. The following 16-bit little-endian field holds address bits 35:32 in bits 3:0 and the length in bits 15:4.
- R5: Requests appear in ascending entry order, one per accepted handshake. While `rq_valid` is high and `rq_ready` is low, the request holds its address and length.
- R6: An entry with length zero produces no request. An entry at an index not below the count also produces no request.
- R7: A count above 20 produces no request. `done` and `err` then pulse together in the second cycle after the last word is accepted.
- R8: `done` pulses for exactly one cycle, one cycle after the last request is accepted. If there is nothing to request, it pulses in the second cycle after the last word. `frame_len` then equals the sum of the requested lengths.
- R9: A frame length above 8192 raises `err` with `done`. A frame length of exactly 8192 does not.
- R10: A requested entry longer than 4092 bytes raises `err` with `done`.
- R11: `wd_ready` is low from the cycle after the last word until after `done`, so no word is taken while requests are outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 28 | Ring base address bits 35:8 |
| ring_idx | input | 8 | Descriptor slot in the ring |
| desc_addr | output | 36 | Byte address of that slot |
| wd_valid | input | 1 | Descriptor word offered |
| wd_ready | output | 1 | Walker takes a word |
| wd_data | input | 32 | Descriptor word |
| rq_valid | output | 1 | Read request offered |
| rq_ready | input | 1 | Request taken downstream |
| rq_addr | output | 36 | Buffer address |
| rq_len | output | 12 | Buffer length in bytes |
| done | output | 1 | One-cycle end-of-descriptor pulse |
| err | output | 1 | Descriptor malformed, valid with done |
| frame_len | output | 17 | Sum of requested lengths, valid with done |

## Verification
Each kind of wrong internal state shows up at the ports in its own way:
- A word counter that is off by one shifts every decoded field, so the first request already carries a wrong address or length.
- A wrong live mask or priority pick shows up as a missing request, an extra request or a reordered request within the same descriptor.
- A stuck pending bit keeps `rq_valid` high past the expected cycle, so `done` arrives late.
- Errors in the length accumulator or its limit checks appear only at the `done` pulse, through `frame_len` and `err`. Descriptors that sit exactly on the 8192 boundary and just above it separate these cases.

// File: rtl/tfd_walk_pkg.sv
package tfd_walk_pkg;

    localparam int ADDR_W      = 36;
    localparam int LEN_W       = 12;
    localparam int WORD_W      = 32;
    localparam int DESC_BYTES  = 128;
    localparam int HDR_BYTES   = 4;
    localparam int ENTRY_BYTES = 6;
    localparam int CNT_W       = 5;
    localparam int CNT_LSB     = 24;
    localparam int DESC_BITS   = DESC_BYTES * 8;
    localparam int DESC_WORDS  = DESC_BYTES / 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } buf_req_t;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_DECODE,
        ST_WALK,
        ST_FINISH
    } walk_state_t;

    // Unpack entry i; odd entries start on a 16-bit boundary.
    function automatic buf_req_t entry_at(input logic [DESC_BITS-1:0] img,
                                          input int unsigned idx);
        buf_req_t   r;
        logic [31:0] lo;
        logic [15:0] hi;
        int unsigned base;
        base   = (HDR_BYTES + idx * ENTRY_BYTES) * 8;
        lo     = img[base +: 32];
        hi     = img[base + 32 +: 16];
        r.addr = {hi[3:0], lo};
        r.len  = hi[15:4];
        return r;
    endfunction

endpackage

// File: rtl/tfd_word_store.sv
module tfd_word_store #(
    parameter int WORDS  = 32,
    parameter int WORD_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  logic [WORD_W-1:0]       data,
    output logic [WORDS*WORD_W-1:0] image,
    output logic                    last
);
    localparam int CW = $clog2(WORDS);

    logic [CW-1:0] wcnt;

    assign last = take && (wcnt == CW'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (take) begin
            wcnt <= last ? '0 : wcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            image[wcnt*WORD_W +: WORD_W] <= data;
        end
    end

    a_r2_count_wraps: assert property (@(posedge clk) disable iff (rst)
        last |=> (wcnt == '0));

endmodule

// File: rtl/tfd_pick_first.sv
module tfd_pick_first #(
    parameter int N  = 20,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
        any = |mask;
    end
endmodule

// File: rtl/tfd_walker.sv
module tfd_walker
    import tfd_walk_pkg::*;
#(
    parameter int MAX_ENTRIES = 20,
    parameter int MAX_BUF     = 4092,
    parameter int MAX_FRAME   = 8192,
    parameter int RING_ALIGN  = 8,
    parameter int SLOT_SHIFT  = 7,
    parameter int IDX_W       = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-RING_ALIGN-1:0] ring_base,
    input  logic [IDX_W-1:0]         ring_idx,
    output logic [ADDR_W-1:0]        desc_addr,
    input  logic                     wd_valid,
    output logic                     wd_ready,
    input  logic [WORD_W-1:0]        wd_data,
    output logic                     rq_valid,
    input  logic                     rq_ready,
    output logic [ADDR_W-1:0]        rq_addr,
    output logic [LEN_W-1:0]         rq_len,
    output logic                     done,
    output logic                     err,
    output logic [$clog2(MAX_ENTRIES*((1<<LEN_W)-1)+1)-1:0] frame_len
);
    localparam int TOT_W = $clog2(MAX_ENTRIES * ((1 << LEN_W) - 1) + 1);
    localparam int EIW   = $clog2(MAX_ENTRIES);

    // Ring slot address
    assign desc_addr = {ring_base, {RING_ALIGN{1'b0}}}
                     + (ADDR_W'(ring_idx) << SLOT_SHIFT);

    walk_state_t              state;
    logic [DESC_BITS-1:0]     image;
    logic                     last_word;
    logic [MAX_ENTRIES-1:0]   pend, pend_clr, live;
    logic [EIW-1:0]           pick_idx;
    logic                     pick_any;
    logic [TOT_W-1:0]         total;
    logic                     big_q, cntbad_q;
    logic [CNT_W-1:0]         cnt;
    logic                     cnt_bad;
    buf_req_t                 ent [MAX_ENTRIES];
    buf_req_t                 cur;

    assign wd_ready = (state == ST_LOAD);

    tfd_word_store #(.WORDS(DESC_WORDS), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .take  (wd_valid && wd_ready),
        .data  (wd_data),
        .image (image),
        .last  (last_word)
    );

    assign cnt     = image[CNT_LSB +: CNT_W];
    assign cnt_bad = cnt > CNT_W'(MAX_ENTRIES);

    for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_ent
        assign ent[g]  = entry_at(image, g);
        assign live[g] = (CNT_W'(g) < cnt) && (ent[g].len != '0);
    end

    tfd_pick_first #(.N(MAX_ENTRIES), .IW(EIW)) u_pick (
        .mask (pend),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    assign cur = ent[pick_idx];

    always_comb begin
        pend_clr           = pend;
        pend_clr[pick_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_LOAD;
            pend     <= '0;
            total    <= '0;
            big_q    <= 1'b0;
            cntbad_q <= 1'b0;
        end else begin
            case (state)
                ST_LOAD: begin
                    if (last_word) state <= ST_DECODE;
                end
                ST_DECODE: begin
                    total    <= '0;
                    big_q    <= 1'b0;
                    cntbad_q <= cnt_bad;
                    pend     <= cnt_bad ? '0 : live;
                    state    <= (cnt_bad || live == '0) ? ST_FINISH : ST_WALK;
                end
                ST_WALK: begin
                    if (rq_ready && pick_any) begin
                        pend  <= pend_clr;
                        total <= total + TOT_W'(cur.len);
                        if (cur.len > LEN_W'(MAX_BUF)) big_q <= 1'b1;
                        if (pend_clr == '0) state <= ST_FINISH;
                    end
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    assign rq_valid  = (state == ST_WALK) && pick_any;
    assign rq_addr   = cur.addr;
    assign rq_len    = cur.len;
    assign done      = (state == ST_FINISH);
    assign frame_len = total;
    assign err       = done && (cntbad_q || big_q || total > TOT_W'(MAX_FRAME));

    // R5: a stalled request keeps its payload
    a_r5_hold_payload: assert property (@(posedge clk) disable iff (rst)
        rq_valid && !rq_ready |=> rq_valid && $stable(rq_addr) && $stable(rq_len));

    // R11: no word intake while requests are pending
    a_r11_no_intake_busy: assert property (@(posedge clk) disable iff (rst)
        rq_valid |-> !wd_ready);

    // R8: done is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: error is only reported alongside done
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R8: each accepted request adds its length to the total
    a_r8_total_grows: assert property (@(posedge clk) disable iff (rst)
        rq_valid && rq_ready |=>
            frame_len == $past(frame_len) + TOT_W'($past(rq_len)));

    // R8: done never coincides with an outstanding request
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !rq_valid);

endmodule

// File: tb/tfd_walker_tb.sv
module tfd_walker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [27:0] ring_base = '0;
    logic [7:0]  ring_idx = '0;
    logic [35:0] desc_addr;
    logic        wd_valid = 1'b0;
    logic        wd_ready;
    logic [31:0] wd_data = '0;
    logic        rq_valid;
    logic        rq_ready = 1'b0;
    logic [35:0] rq_addr;
    logic [11:0] rq_len;
    logic        done, err;
    logic [16:0] frame_len;

    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 0;

    logic [7:0] d [128];

    always #10 clk = ~clk;

    tfd_walker u_dut (
        .clk(clk), .rst(rst),
        .ring_base(ring_base), .ring_idx(ring_idx), .desc_addr(desc_addr),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_len(rq_len),
        .done(done), .err(err), .frame_len(frame_len)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill_bg(int seed);
        for (int k = 0; k < 128; k++) d[k] = 8'(k * 7 + seed);
    endtask

    task automatic set_count(logic [7:0] b);
        d[3] = b;
    endtask

    task automatic put_entry(int i, logic [35:0] a, int ln);
        int b;
        logic [15:0] hi;
        b  = 4 + 6 * i;
        hi = {ln[11:0], a[35:32]};
        d[b]   = a[7:0];
        d[b+1] = a[15:8];
        d[b+2] = a[23:16];
        d[b+3] = a[31:24];
        d[b+4] = hi[7:0];
        d[b+5] = hi[15:8];
    endtask

    // Send the descriptor, then follow requests up to done and compare
    // against a model built from the requirements.
    task automatic run_desc(string tag, int stall_mode);
        logic [35:0] ea [20];
        int          el [20];
        int ne, cnt, total, k, iter, last_acc;
        bit exp_err, cnt_bad, prev_stall, rdy;
        logic [35:0] keep_a;
        logic [11:0] keep_l;
        ne = 0; total = 0; exp_err = 0;
        cnt = int'(d[3][4:0]);
        cnt_bad = cnt > 20;
        if (!cnt_bad) begin
            for (int i = 0; i < cnt; i++) begin
                int b;
                int ln;
                b  = 4 + 6 * i;
                ln = int'({d[b+5], d[b+4]} >> 4);
                if (ln != 0) begin
                    ea[ne] = {d[b+4][3:0], d[b+3], d[b+2], d[b+1], d[b]};
                    el[ne] = ln;
                    ne++;
                    total += ln;
                    if (ln > 4092) exp_err = 1;
                end
            end
        end
        if (total > 8192 || cnt_bad) exp_err = 1;

        for (int w = 0; w < 32; w++) begin
            @(negedge clk);
            wd_valid = 1'b1;
            wd_data  = {d[4*w+3], d[4*w+2], d[4*w+1], d[4*w]};
            if (w == 0) chk("R2", {tag, " wd_ready at start"}, wd_ready, 1);
        end

        k = 0; iter = 0; last_acc = -10; prev_stall = 0;
        keep_a = '0; keep_l = '0;
        forever begin
            @(negedge clk);
            wd_valid = 1'b0;
            iter++;
            if (done) break;
            if (iter > 300) begin
                chk("R8", {tag, " done never seen"}, 0, 1);
                break;
            end
            if (rq_valid) begin
                chk("R11", {tag, " wd_ready while busy"}, wd_ready, 0);
                if (k < ne) begin
                    chk("R4", {tag, " rq_addr"}, rq_addr, ea[k]);
                    chk("R4", {tag, " rq_len"}, rq_len, el[k]);
                end else begin
                    chk("R6", {tag, " extra request"}, k, ne - 1);
                end
                if (prev_stall) begin
                    chk("R5", {tag, " addr held"}, rq_addr, keep_a);
                    chk("R5", {tag, " len held"}, rq_len, keep_l);
                end
                rdy = (stall_mode == 0) || (iter % 3 == 0);
                rq_ready = rdy;
                keep_a = rq_addr;
                keep_l = rq_len;
                if (rdy) begin
                    k++;
                    last_acc = iter;
                end
                prev_stall = !rdy;
            end else begin
                rq_ready = 1'b0;
            end
        end
        rq_ready = 1'b0;
        chk("R6", {tag, " request count"}, k, ne);
        if (ne > 0) chk("R8", {tag, " done timing"}, iter, last_acc + 1);
        else if (cnt_bad) chk("R7", {tag, " done timing"}, iter, 2);
        else chk("R8", {tag, " done timing empty"}, iter, 2);
        chk(cnt_bad ? "R7" : (total > 8192 ? "R9" : "R10"), {tag, " err"}, err, exp_err);
        chk("R8", {tag, " frame_len"}, frame_len, total);
        @(negedge clk);
        chk("R8", {tag, " done one cycle"}, done, 0);
        chk("R2", {tag, " ready again"}, wd_ready, 1);
    endtask

    task automatic t_reset;
        chk("R2", "reset wd_ready", wd_ready, 1);
        chk("R5", "reset rq_valid", rq_valid, 0);
        chk("R8", "reset done", done, 0);
    endtask

    task automatic t_slot_addr;
        ring_base = 28'h1234567; ring_idx = 8'd5;
        #1 chk("R1", "slot 5", desc_addr, {28'h1234567, 8'h00} + 36'd640);
        ring_base = 28'hFFFFF00; ring_idx = 8'd255;
        #1 chk("R1", "slot 255", desc_addr, {28'hFFFFF00, 8'h00} + 36'd32640);
        ring_base = 28'h0000001; ring_idx = 8'd0;
        #1 chk("R1", "slot 0", desc_addr, 36'h100);
    endtask

    task automatic t_basic;
        fill_bg(1);
        set_count(8'hE3);   // R3: upper bits set, count 3
        put_entry(0, 36'h9_1234_5678, 100);
        put_entry(1, 36'hA_8765_4321, 200);
        put_entry(2, 36'h0_0000_0010, 4092);
        run_desc("basic R3", 0);
    endtask

    task automatic t_skip_stall;
        fill_bg(5);
        set_count(8'd6);    // entries 6 and up hold nonzero background
        put_entry(0, 36'h1_0000_0000, 0);
        put_entry(1, 36'h2_1111_1111, 64);
        put_entry(2, 36'h3_2222_2222, 0);
        put_entry(3, 36'h4_3333_3333, 1);
        put_entry(4, 36'h5_4444_4444, 2048);
        put_entry(5, 36'h6_5555_5555, 0);
        run_desc("skip R6 stall R5", 1);
    endtask

    task automatic t_full;
        fill_bg(9);
        set_count(8'd20);
        for (int i = 0; i < 20; i++) put_entry(i, 36'(i) * 36'h1_0001_0003, 400);
        run_desc("full twenty", 1);
    endtask

    task automatic t_bad_count;
        fill_bg(3);
        set_count(8'd21);
        for (int i = 0; i < 20; i++) put_entry(i, 36'h100 + 36'(i), 16);
        run_desc("count 21 R7", 0);
    endtask

    task automatic t_frame_limit;
        fill_bg(11);
        set_count(8'd3);
        put_entry(0, 36'hF_0000_0004, 4092);
        put_entry(1, 36'hE_0000_0008, 4092);
        put_entry(2, 36'hD_0000_000C, 8);
        run_desc("exact 8192 R9", 0);
        put_entry(2, 36'hD_0000_000C, 9);
        run_desc("8193 R9", 0);
    endtask

    task automatic t_big_buf;
        fill_bg(13);
        set_count(8'd2);
        put_entry(0, 36'h7_7777_7770, 4093);
        put_entry(1, 36'h8_0000_0000, 0);
        run_desc("buffer 4093 R10", 0);
    endtask

    task automatic t_empty;
        fill_bg(17);
        set_count(8'h20);   // R3: bit 5 set, count 0
        run_desc("count 0 R3", 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!summary_done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            summary_done = 1;
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_slot_addr();
        t_basic();
        t_skip_stall();
        t_full();
        t_bad_count();
        t_frame_limit();
        t_big_buf();
        t_empty();
        if (!summary_done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            summary_done = 1;
        end
        $finish;
    end

endmodule